// File: doc/BRIEF.md
# Byte-Wide Flash Command Front End

This block is the bus-side front end of a byte-wide flash memory emulator. It watches an asynchronous-style parallel bus (active-low chip-enable, write-enable and output-enable) in its own clock domain. A write cycle is committed when write-enable rises while chip-enable is low. At that moment the block captures the address and data lines. It walks the captured writes through an unlock-prefixed command grammar, and it hands each decoded program or erase request to a separate engine over a one-cycle request strobe. The engine replies with a one-cycle completion pulse.

Reads are served in two ways. While no operation is running, the block passes the address to the storage array and returns the array byte. While a program or erase is running, a read returns a status byte instead. Two independent toggle bits in that byte let software detect progress. One toggle bit flips on every status read. The other flips only when the address being read lies in a sector marked for erase. An erase can be suspended so that other sectors can be read or programmed, and then resumed.

Sectors are of uniform size and a power of two. The top address bits select the sector.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset is released the block is in read-array mode. No request has been issued, and a read returns the array byte for the read address.
- R2: `dout` carries data only while both `ce_n` and `oe_n` are low. At all other times `dout` is 0 and `dout_en` is low.
- R3: A write commits on a rising `we_n` while `ce_n` is low. The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555 followed by a data write produces one `req_valid` pulse with `req_op` 0 (program), `req_addr` equal to the final write's address and `req_data` equal to its data. Unlock addresses compare on address bits [10:0].
- R4: A write that does not fit the expected next step of a sequence returns the decoder to read-array mode. So does 0xF0, written in any step except the program-data step. Neither issues a request.
- R5: The erase sequence is 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then a final write. A final write of 0x10@0x555 requests a chip erase (`req_op` 2) and marks every sector. A final write of 0x30 at any address requests a sector erase (`req_op` 1) and marks the sector given by address bits [16:14].
- R6: While an operation is in progress, a read returns a status byte. Bit 6 of that byte inverts on every successive read. Bit 7 is the complement of bit 7 of the data being programmed during a program, and 0 during an erase. Bits 5, 4, 3, 1 and 0 are 0. After the engine's `eng_done` pulse, reads return array data again.
- R7: Status bit 2 inverts on successive reads only when the read address lies in a sector marked for erase. Otherwise it holds its value.
- R8: While an operation runs and no erase is suspended, every write other than 0xB0 and 0xF0 is ignored. This includes unlock sequences and 0x30.
- R9: 0xB0 written during an erase raises one `susp_req` pulse. While suspended, reads from unmarked sectors return array data and reads from marked sectors return status. 0x30 written in read-array mode while suspended raises one `resume_req` pulse, and full status reporting resumes.
- R10: During a suspended erase, a program sequence is accepted when its target lies outside the marked sectors. It is dropped without a request when the target lies inside them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset, forces read-array mode |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low, commits on rising edge |
| oe_n | input | 1 | Bus output enable, active low |
| addr | input | 17 | Bus byte address |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data, 0 when not enabled |
| dout_en | output | 1 | High while read data is driven |
| arr_addr | output | 17 | Address to the storage array |
| arr_rdata | input | 8 | Byte returned by the storage array |
| req_valid | output | 1 | One-cycle request strobe to the engine |
| req_op | output | 2 | Request kind: 0 program, 1 sector erase, 2 chip erase |
| req_addr | output | 17 | Latched request address |
| req_data | output | 8 | Latched program data |
| susp_req | output | 1 | One-cycle erase-suspend strobe |
| resume_req | output | 1 | One-cycle erase-resume strobe |
| eng_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The in-line properties hold on every cycle for several things:
- A suspend always sits on top of a running erase.
- The sector marks are clear whenever no erase runs.
- The engine strobes never coincide.
- No request leaves while the interface is locked.
- No program request targets a sector being erased.
- Neither toggle register moves without a status read.

Only the bench scenarios can show the command grammar end to end:
- the exact request fields;
- that broken or reset sequences leave no trace;
- the read-path choice between array data and status around suspend and completion;
- the alternation seen by software on successive reads.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2
   } fop_e;

   localparam int          UL_AW      = 11;
   localparam logic [10:0] UL_ADDR1   = 11'h555;
   localparam logic [10:0] UL_ADDR2   = 11'h2AA;
   localparam logic [7:0]  CMD_UL1    = 8'hAA;
   localparam logic [7:0]  CMD_UL2    = 8'h55;
   localparam logic [7:0]  CMD_PROG   = 8'hA0;
   localparam logic [7:0]  CMD_ERASE  = 8'h80;
   localparam logic [7:0]  CMD_CHIP   = 8'h10;
   localparam logic [7:0]  CMD_SECT   = 8'h30;
   localparam logic [7:0]  CMD_RESUME = 8'h30;
   localparam logic [7:0]  CMD_SUSP   = 8'hB0;
   localparam logic [7:0]  CMD_RESET  = 8'hF0;
endpackage

// File: rtl/flash_cmd_sync.sv
module flash_cmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   output logic wr_pulse,
   output logic rd_pulse
);
   // bit 2 = ce, bit 1 = we, bit 0 = oe (all active low)
   logic [2:0] stg [STAGES];
   logic [2:0] last;
   logic [2:0] cur;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("flash_cmd_sync: STAGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= 3'b111;
         last <= 3'b111;
      end else begin
         stg[0] <= {ce_n, we_n, oe_n};
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         last <= stg[STAGES-1];
      end
   end

   assign cur      = stg[STAGES-1];
   assign wr_pulse = cur[1] & ~last[1] & ~cur[2];
   assign rd_pulse = ~cur[0] & last[0] & ~cur[2];
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   localparam int NSECT    = 1 << SECT_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              eng_done,
   output logic              req_valid,
   output fop_e              req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              susp_req,
   output logic              resume_req,
   output logic              prog_run,
   output logic              erase_run,
   output logic              suspended,
   output logic [NSECT-1:0]  erase_mask,
   output logic              prog_bit7
);
   typedef enum logic [2:0] {S_READ, S_UL1, S_UL2, S_PROG, S_ER1, S_ER2, S_ER3} st_e;
   st_e st;

   logic                 at1, at2, locked;
   logic [SECT_BITS-1:0] wsect;
   logic [7:0]           wcmd;

   assign wcmd   = wdata[7:0];
   assign at1    = (waddr[UL_AW-1:0] == UL_ADDR1);
   assign at2    = (waddr[UL_AW-1:0] == UL_ADDR2);
   assign wsect  = waddr[ADDR_W-1 -: SECT_BITS];
   assign locked = prog_run || (erase_run && !suspended);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_READ;
         req_valid  <= 1'b0;
         req_op     <= OP_PROG;
         req_addr   <= '0;
         req_data   <= '0;
         susp_req   <= 1'b0;
         resume_req <= 1'b0;
         prog_run   <= 1'b0;
         erase_run  <= 1'b0;
         suspended  <= 1'b0;
         erase_mask <= '0;
         prog_bit7  <= 1'b0;
      end else begin
         req_valid  <= 1'b0;
         susp_req   <= 1'b0;
         resume_req <= 1'b0;
         if (eng_done) begin
            if (prog_run) prog_run <= 1'b0;
            else begin
               erase_run  <= 1'b0;
               suspended  <= 1'b0;
               erase_mask <= '0;
            end
         end
         if (wr) begin
            if (wcmd == CMD_RESET && st != S_PROG) begin
               st <= S_READ;
            end else if (locked) begin
               if (wcmd == CMD_SUSP && erase_run && !prog_run) begin
                  suspended <= 1'b1;
                  susp_req  <= 1'b1;
               end
            end else if (suspended && st == S_READ && wcmd == CMD_RESUME) begin
               suspended  <= 1'b0;
               resume_req <= 1'b1;
            end else begin
               unique case (st)
                  S_READ: st <= (at1 && wcmd == CMD_UL1) ? S_UL1 : S_READ;
                  S_UL1:  st <= (at2 && wcmd == CMD_UL2) ? S_UL2 : S_READ;
                  S_UL2: begin
                     if (at1 && wcmd == CMD_PROG) st <= S_PROG;
                     else if (at1 && wcmd == CMD_ERASE && !suspended) st <= S_ER1;
                     else st <= S_READ;
                  end
                  S_PROG: begin
                     st <= S_READ;
                     if (!(suspended && erase_mask[wsect])) begin
                        req_valid <= 1'b1;
                        req_op    <= OP_PROG;
                        req_addr  <= waddr;
                        req_data  <= wdata;
                        prog_run  <= 1'b1;
                        prog_bit7 <= wdata[7];
                     end
                  end
                  S_ER1: st <= (at1 && wcmd == CMD_UL1) ? S_ER2 : S_READ;
                  S_ER2: st <= (at2 && wcmd == CMD_UL2) ? S_ER3 : S_READ;
                  S_ER3: begin
                     st <= S_READ;
                     if (at1 && wcmd == CMD_CHIP) begin
                        req_valid  <= 1'b1;
                        req_op     <= OP_CHIP;
                        req_addr   <= waddr;
                        erase_run  <= 1'b1;
                        erase_mask <= '1;
                     end else if (wcmd == CMD_SECT) begin
                        req_valid  <= 1'b1;
                        req_op     <= OP_SECT;
                        req_addr   <= waddr;
                        erase_run  <= 1'b1;
                        erase_mask <= {{(NSECT-1){1'b0}}, 1'b1} << wsect;
                     end
                  end
                  default: st <= S_READ;
               endcase
            end
         end
      end
   end

   AST_SUSP_NEEDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> erase_run); // R9
   AST_MASK_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_run |-> (erase_mask == '0)); // R5
   AST_REQ_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (prog_run || erase_run)); // R3
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_valid, susp_req, resume_req})); // R8
   AST_LOCKED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !$past(locked)); // R8
   AST_NO_PROG_IN_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PROG && suspended)
         |-> !erase_mask[req_addr[ADDR_W-1 -: SECT_BITS]]); // R10
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status #(
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   parameter int T6_BIT    = 6,
   parameter int T2_BIT    = 2,
   parameter int B7_BIT    = 7,
   localparam int NSECT    = 1 << SECT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd,
   input  logic [SECT_BITS-1:0] rd_sect,
   input  logic                 ce_n,
   input  logic                 oe_n,
   input  logic [DATA_W-1:0]    arr_rdata,
   input  logic                 prog_run,
   input  logic                 erase_run,
   input  logic                 suspended,
   input  logic [NSECT-1:0]     erase_mask,
   input  logic                 prog_bit7,
   output logic [DATA_W-1:0]    dout,
   output logic                 dout_en
);
   logic              hit, stat, t6, t2;
   logic [DATA_W-1:0] sbyte;

   generate
      if (B7_BIT >= DATA_W || T6_BIT >= DATA_W || T2_BIT >= DATA_W) begin : g_bad_bits
         $error("flash_cmd_status: status bit positions exceed DATA_W");
      end
   endgenerate

   assign hit  = erase_mask[rd_sect];
   assign stat = prog_run || (erase_run && !suspended) || (suspended && hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t6 <= 1'b0;
         t2 <= 1'b0;
      end else if (rd && stat) begin
         t6 <= ~t6;
         if (hit) t2 <= ~t2;
      end
   end

   always_comb begin
      sbyte         = '0;
      sbyte[B7_BIT] = prog_run ? ~prog_bit7 : 1'b0;
      sbyte[T6_BIT] = t6;
      sbyte[T2_BIT] = t2;
   end

   assign dout_en = !ce_n && !oe_n;
   assign dout    = dout_en ? (stat ? sbyte : arr_rdata) : '0;

   AST_T6_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && stat) |=> $stable(t6)); // R6
   AST_T2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && stat && hit) |=> $stable(t2)); // R7
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int SECT_BITS   = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NSECT      = 1 << SECT_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              req_valid,
   output logic [1:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              susp_req,
   output logic              resume_req,
   input  logic              eng_done
);
   generate
      if (ADDR_W <= UL_AW || SECT_BITS < 1 || SECT_BITS > ADDR_W - UL_AW) begin : g_bad_addr
         $error("flash_cmd_front: ADDR_W or SECT_BITS out of range");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("flash_cmd_front: DATA_W must be at least 8");
      end
   endgenerate

   logic             wr, rd;
   logic             prog_run, erase_run, suspended, prog_bit7;
   logic [NSECT-1:0] erase_mask;
   fop_e             op;

   flash_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .wr_pulse(wr), .rd_pulse(rd)
   );

   flash_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr(wr), .waddr(addr), .wdata(din),
      .eng_done(eng_done), .req_valid(req_valid), .req_op(op),
      .req_addr(req_addr), .req_data(req_data), .susp_req(susp_req),
      .resume_req(resume_req), .prog_run(prog_run), .erase_run(erase_run),
      .suspended(suspended), .erase_mask(erase_mask), .prog_bit7(prog_bit7)
   );

   flash_cmd_status #(.DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd(rd), .rd_sect(addr[ADDR_W-1 -: SECT_BITS]),
      .ce_n(ce_n), .oe_n(oe_n), .arr_rdata(arr_rdata), .prog_run(prog_run),
      .erase_run(erase_run), .suspended(suspended), .erase_mask(erase_mask),
      .prog_bit7(prog_bit7), .dout(dout), .dout_en(dout_en)
   );

   assign req_op   = op;
   assign arr_addr = addr;
endmodule

// File: tb/flash_cmd_front_bench.sv
`timescale 1ns/1ps
module flash_cmd_front_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout, arr_rdata, req_data;
   logic        dout_en, req_valid, susp_req, resume_req;
   logic        eng_done = 1'b0;
   logic [16:0] arr_addr, req_addr;
   logic [1:0]  req_op;

   int nchk = 0, nfail = 0;
   int nreq = 0, nsusp = 0, nres = 0;
   logic [1:0]  last_op;
   logic [16:0] last_addr;
   logic [7:0]  last_data;

   always #2 clk = ~clk;

   flash_cmd_front u_flash_cmd_front (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .arr_addr(arr_addr), .arr_rdata(arr_rdata), .req_valid(req_valid),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .susp_req(susp_req), .resume_req(resume_req), .eng_done(eng_done)
   );

   function automatic logic [7:0] amodel(input logic [16:0] a);
      return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
   endfunction
   assign arr_rdata = amodel(arr_addr);

   always @(posedge clk) begin
      if (req_valid) begin
         nreq++; last_op = req_op; last_addr = req_addr; last_data = req_data;
      end
      if (susp_req) nsusp++;
      if (resume_req) nres++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [16:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (5) @(negedge clk);
      ce_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd(input logic [16:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      repeat (4) @(negedge clk);
      d = dout;
      oe_n = 1'b1; ce_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic prog_seq(input logic [16:0] a, input logic [7:0] d);
      wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55); wr(17'h555, 8'hA0); wr(a, d);
   endtask

   task automatic erase_prefix();
      wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55); wr(17'h555, 8'h80);
      wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55);
   endtask

   task automatic done();
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] r0, r1, r2;
      int base, s0;
      s0 = $urandom(32'h5EED_1234);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk(nreq == 0, "R1 no request after reset", nreq, 0);
      rd(17'h01234, r0);
      chk(r0 == amodel(17'h01234), "R1 array read after reset", r0, amodel(17'h01234));

      // R2 output enable gating
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
      chk(dout == 8'h00 && !dout_en, "R2 oe high", {dout_en, dout}, 0);
      ce_n = 1'b1; oe_n = 1'b0; #1;
      chk(dout == 8'h00 && !dout_en, "R2 ce high", {dout_en, dout}, 0);
      ce_n = 1'b0; addr = 17'h00300; #1;
      chk(dout_en && dout == amodel(17'h00300), "R2 both low", dout, amodel(17'h00300));
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3 program request
      base = nreq;
      prog_seq(17'h1ABCD, 8'h5A);
      chk(nreq == base + 1, "R3 one request", nreq, base + 1);
      chk(last_op == 2'd0 && last_addr == 17'h1ABCD && last_data == 8'h5A, "R3 fields",
          {last_op, last_addr, last_data}, {2'd0, 17'h1ABCD, 8'h5A});
      // R6 status during program
      rd(17'h00010, r0); rd(17'h00010, r1);
      chk(r0[7] == 1'b1 && r1[7] == 1'b1, "R6 bit7 complement", {r0[7], r1[7]}, 2'b11);
      chk(r0[6] != r1[6], "R6 bit6 toggles", {r0, r1}, 0);
      chk((r0 & 8'h3B) == 0 && (r1 & 8'h3B) == 0, "R6 unused bits zero", {r0, r1}, 0);
      chk(r0[2] == r1[2], "R7 bit2 holds without erase", {r0[2], r1[2]}, {r0[2], r0[2]});
      // R8 writes ignored while busy
      base = nreq;
      prog_seq(17'h00100, 8'h11);
      chk(nreq == base, "R8 program ignored while busy", nreq, base);
      done();
      rd(17'h1ABCD, r0);
      chk(r0 == amodel(17'h1ABCD), "R6 array after done", r0, amodel(17'h1ABCD));

      // R4 broken sequence and reset command
      base = nreq;
      wr(17'h555, 8'hAA); wr(17'h2AA, 8'h12); wr(17'h2AA, 8'h55); wr(17'h555, 8'hA0); wr(17'h00040, 8'h77);
      chk(nreq == base, "R4 broken sequence", nreq, base);
      wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55); wr(17'h00000, 8'hF0); wr(17'h555, 8'hA0); wr(17'h00040, 8'h77);
      chk(nreq == base, "R4 reset command", nreq, base);
      rd(17'h00040, r0);
      chk(r0 == amodel(17'h00040), "R4 read mode kept", r0, amodel(17'h00040));

      // R5 sector erase of sector 2 (addr[16:14]=3'b010)
      base = nreq;
      erase_prefix(); wr(17'h08123, 8'h30);
      chk(nreq == base + 1 && last_op == 2'd1 && last_addr == 17'h08123, "R5 sector erase",
          {last_op, last_addr}, {2'd1, 17'h08123});
      rd(17'h08000, r0); rd(17'h08000, r1);
      chk(r0[2] != r1[2] && r0[6] != r1[6], "R7 bit2 toggles in erasing sector", {r0, r1}, 0);
      chk(r0[7] == 1'b0, "R6 bit7 zero during erase", r0[7], 0);
      rd(17'h14000, r0); rd(17'h14000, r1);
      chk(r0[2] == r1[2] && r0[6] != r1[6], "R7 bit2 holds outside erasing sector", {r0, r1}, 0);
      // R8 resume ignored while running
      base = nres;
      wr(17'h00000, 8'h30);
      chk(nres == base, "R8 resume ignored when not suspended", nres, base);

      // R9 suspend
      base = nsusp;
      wr(17'h00000, 8'hB0);
      chk(nsusp == base + 1, "R9 suspend strobe", nsusp, base + 1);
      rd(17'h14000, r0);
      chk(r0 == amodel(17'h14000), "R9 array read outside erasing sector", r0, amodel(17'h14000));
      rd(17'h08000, r0); rd(17'h08000, r1);
      chk(r0[6] != r1[6], "R9 status in erasing sector", {r0, r1}, 0);
      // R10 program while suspended
      base = nreq;
      prog_seq(17'h08200, 8'h33);
      chk(nreq == base, "R10 program in erasing sector dropped", nreq, base);
      prog_seq(17'h14200, 8'h9C);
      chk(nreq == base + 1 && last_op == 2'd0 && last_addr == 17'h14200 && last_data == 8'h9C,
          "R10 program outside erasing sector", {last_op, last_addr, last_data}, {2'd0, 17'h14200, 8'h9C});
      rd(17'h14000, r0);
      chk(r0[7] == 1'b0, "R6 bit7 complement of 0x9C", r0[7], 0);
      done();
      base = nres;
      wr(17'h00000, 8'h30);
      chk(nres == base + 1, "R9 resume strobe", nres, base + 1);
      rd(17'h14000, r0); rd(17'h14000, r1);
      chk(r0[6] != r1[6], "R9 status after resume", {r0, r1}, 0);
      done();
      rd(17'h08000, r0);
      chk(r0 == amodel(17'h08000), "R6 array after erase done", r0, amodel(17'h08000));

      // R5 chip erase marks every sector
      base = nreq;
      erase_prefix(); wr(17'h00555, 8'h10);
      chk(nreq == base + 1 && last_op == 2'd2, "R5 chip erase", last_op, 2'd2);
      rd(17'h1C000, r0); rd(17'h1C000, r1);
      chk(r0[2] != r1[2], "R7 bit2 toggles under chip erase", {r0, r1}, 0);
      done();

      // R3 random programs, R1 random array reads
      for (int i = 0; i < 30; i++) begin
         logic [16:0] ra;
         logic [7:0]  rdat;
         ra = 17'($urandom); rdat = 8'($urandom);
         base = nreq;
         prog_seq(ra, rdat);
         chk(nreq == base + 1 && last_addr == ra && last_data == rdat && last_op == 2'd0,
             "R3 random program", {last_addr, last_data}, {ra, rdat});
         rd(ra ^ 17'h00F0F, r2);
         chk(r2[7] == ~rdat[7], "R6 random bit7", r2[7], ~rdat[7]);
         done();
         rd(ra, r2);
         chk(r2 == amodel(ra), "R1 random array read", r2, amodel(ra));
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule